// File: doc/BRIEF.md
# Two-Wire Slave Address Matcher

This block decides whether an address byte received on a two-wire serial bus selects the local device in slave mode. A bit-level receiver presents the assembled byte together with a one-cycle valid strobe. The block compares the upper bits of that byte against the address programmed in the local address register. Bit 0 of that register permits the broadcast address zero to be recognised as a general call. The block then reports how the device was selected, whether the master wants to read or write, and whether the device should drive ACK for the address byte. It also produces an 8-bit status code that the data-phase logic can use.

The decision is held in a small state machine. It has five states:

- `ST_IDLE`: after reset, no byte seen yet.
- `ST_MISS`: last byte did not select the device, or acknowledge was disabled.
- `ST_OWN_WR`: own address with write.
- `ST_OWN_RD`: own address with read.
- `ST_GCALL`: general call accepted.

The state changes only on a clock edge where the strobe is high. From any state, the strobe moves the machine to the state chosen by the comparison: `ST_MISS`, `ST_OWN_WR`, `ST_OWN_RD` or `ST_GCALL`. Without a strobe the machine stays where it is. Reset returns it to `ST_IDLE`. All outputs are decoded from the state alone. They are therefore valid in the cycle after the strobe and stay unchanged until the next strobe.

Top module: `slv_addr_match`

## Requirements
- R1: During and after reset, until the first strobe, `sel_own`, `sel_gcall`, `dir_read` and `ack_drive` are 0 and `status` is 0xF8.
- R2: A strobed byte whose bits 7..1 equal bits 7..1 of `own_reg` and whose bit 0 is 0 (write) gives `sel_own`=1, `dir_read`=0, `ack_drive`=1, `sel_gcall`=0 and `status`=0x60 in the next cycle. This applies when `ack_en` is 1 and the address is nonzero. In every state, `ack_drive` is 1 exactly when `sel_own` or `sel_gcall` is 1.
- R3: The same match with byte bit 0 equal to 1 (read) gives `sel_own`=1, `dir_read`=1, `ack_drive`=1 and `status`=0xA8. `dir_read` is never 1 without `sel_own`.
- R4: The byte 0x00 gives `sel_gcall`=1, `sel_own`=0, `dir_read`=0, `ack_drive`=1 and `status`=0x70 when `own_reg` bit 0 is 1 and `ack_en` is 1.
- R5: The byte 0x00 selects nothing when `own_reg` bit 0 is 0: all flags are 0 and `status` is 0xF8.
- R6: The byte 0x01, which is the broadcast address with read, never selects the device.
- R7: An own-address field of zero (`own_reg` bits 7..1 all 0) never produces `sel_own`. Address zero can select the device only through the general-call path.
- R8: When `ack_en` is 0 at the strobe, the next cycle shows all flags 0 and `status` 0xF8, whatever the byte.
- R9: While the strobe is low, all outputs hold their values, even when `addr_byte`, `own_reg` and `ack_en` change.
- R10: Any other byte gives all flags 0 and `status` 0xF8. This includes a miss that follows an earlier match.
- R11: With parameter `GC_SUPPORT`=0, `sel_gcall` is never 1 and the byte 0x00 selects nothing. Own-address matching is unchanged in this variant.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr_vld | input | 1 | One-cycle strobe: `addr_byte` holds a complete address byte |
| addr_byte | input | ADDR_W+1 | Received byte: address in upper bits, read flag in bit 0 |
| own_reg | input | ADDR_W+1 | Local address in upper bits, general-call enable in bit 0 |
| ack_en | input | 1 | Allows the device to acknowledge its address |
| sel_own | output | 1 | Selected by its own address |
| sel_gcall | output | 1 | Selected by a general call |
| dir_read | output | 1 | Master requested a read (device transmits) |
| ack_drive | output | 1 | Drive ACK for the address byte |
| status | output | STAT_W | Selection status code |

## Verification
The bench builds two copies of the block with `ADDR_W`=7. One has general-call support enabled and the other has it disabled. Both see the same stimulus, so each byte shows the behaviour of both variants side by side. With a 7-bit address, every one of the 256 byte values can be swept against a fixed own address. This covers both read flags, the broadcast byte and every near-miss address. Zero-valued own-address fields and disabled acknowledge are driven as separate cases.

// File: rtl/sam_pkg.sv
package sam_pkg;

    // Selection state held between address bytes
    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_MISS   = 3'd1,
        ST_OWN_WR = 3'd2,
        ST_OWN_RD = 3'd3,
        ST_GCALL  = 3'd4
    } sel_state_t;

endpackage

// File: rtl/sam_field_cmp.sv
// Splits the received byte and the local address register into fields and
// compares the address fields bit by bit.
module sam_field_cmp #(
    parameter int ADDR_W = 7
) (
    input  logic [ADDR_W:0] rx_byte,
    input  logic [ADDR_W:0] own_reg,
    output logic            own_eq,
    output logic            rx_zero,
    output logic            own_zero,
    output logic            rx_read,
    output logic            gc_en
);

    logic [ADDR_W-1:0] bit_eq;

    genvar g;
    for (g = 0; g < ADDR_W; g++) begin : g_bit
        assign bit_eq[g] = ~(rx_byte[g+1] ^ own_reg[g+1]);
    end

    assign own_eq   = &bit_eq;
    assign rx_zero  = ~|rx_byte[ADDR_W:1];
    assign own_zero = ~|own_reg[ADDR_W:1];
    assign rx_read  = rx_byte[0];
    assign gc_en    = own_reg[0];

endmodule

// File: rtl/sam_gc_gate.sv
// Broadcast recognition; GC_SUPPORT selects whether the path exists at all.
module sam_gc_gate #(
    parameter bit GC_SUPPORT = 1'b1
) (
    input  logic gc_en,
    input  logic rx_zero,
    input  logic rx_read,
    output logic gc_cand
);

    if (GC_SUPPORT) begin : g_gc
        // a broadcast with the read flag set is not a valid general call
        assign gc_cand = gc_en & rx_zero & ~rx_read;
    end else begin : g_no_gc
        logic unused_gc_in;
        assign unused_gc_in = ^{gc_en, rx_zero, rx_read};
        assign gc_cand      = 1'b0;
    end

endmodule

// File: rtl/sam_next_sel.sv
// Chooses the state entered when an address byte is strobed in.
module sam_next_sel
    import sam_pkg::*;
(
    input  logic       own_eq,
    input  logic       own_zero,
    input  logic       rx_read,
    input  logic       gc_cand,
    input  logic       ack_en,
    output sel_state_t nxt_sel
);

    always_comb begin
        nxt_sel = ST_MISS;
        if (!ack_en) begin
            nxt_sel = ST_MISS;
        end else if (gc_cand) begin
            nxt_sel = ST_GCALL;
        end else if (own_eq && !own_zero) begin
            nxt_sel = rx_read ? ST_OWN_RD : ST_OWN_WR;
        end
    end

endmodule

// File: rtl/slv_addr_match.sv
module slv_addr_match
    import sam_pkg::*;
#(
    parameter int              ADDR_W        = 7,
    parameter bit              GC_SUPPORT    = 1'b1,
    parameter int              STAT_W        = 8,
    parameter logic [STAT_W-1:0] STAT_OWN_WR = 8'h60,
    parameter logic [STAT_W-1:0] STAT_OWN_RD = 8'hA8,
    parameter logic [STAT_W-1:0] STAT_GCALL  = 8'h70,
    parameter logic [STAT_W-1:0] STAT_NONE   = 8'hF8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              addr_vld,
    input  logic [ADDR_W:0]   addr_byte,
    input  logic [ADDR_W:0]   own_reg,
    input  logic              ack_en,
    output logic              sel_own,
    output logic              sel_gcall,
    output logic              dir_read,
    output logic              ack_drive,
    output logic [STAT_W-1:0] status
);

    localparam int BYTE_W = ADDR_W + 1;

    logic       own_eq, rx_zero, own_zero, rx_read, gc_en, gc_cand;
    sel_state_t sel_q, nxt_sel;

    sam_field_cmp #(.ADDR_W(ADDR_W)) u_cmp (
        .rx_byte (addr_byte),
        .own_reg (own_reg),
        .own_eq  (own_eq),
        .rx_zero (rx_zero),
        .own_zero(own_zero),
        .rx_read (rx_read),
        .gc_en   (gc_en)
    );

    sam_gc_gate #(.GC_SUPPORT(GC_SUPPORT)) u_gc (
        .gc_en  (gc_en),
        .rx_zero(rx_zero),
        .rx_read(rx_read),
        .gc_cand(gc_cand)
    );

    sam_next_sel u_nxt (
        .own_eq  (own_eq),
        .own_zero(own_zero),
        .rx_read (rx_read),
        .gc_cand (gc_cand),
        .ack_en  (ack_en),
        .nxt_sel (nxt_sel)
    );

    // State register: only a strobed byte moves the selection
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sel_q <= ST_IDLE;
        end else if (addr_vld) begin
            sel_q <= nxt_sel;
        end
    end

    // Outputs decoded from the state alone
    always_comb begin
        sel_own   = 1'b0;
        sel_gcall = 1'b0;
        dir_read  = 1'b0;
        ack_drive = 1'b0;
        status    = STAT_NONE;
        unique case (sel_q)
            ST_IDLE, ST_MISS: begin
                status = STAT_NONE;
            end
            ST_OWN_WR: begin
                sel_own   = 1'b1;
                ack_drive = 1'b1;
                status    = STAT_OWN_WR;
            end
            ST_OWN_RD: begin
                sel_own   = 1'b1;
                dir_read  = 1'b1;
                ack_drive = 1'b1;
                status    = STAT_OWN_RD;
            end
            ST_GCALL: begin
                sel_gcall = 1'b1;
                ack_drive = 1'b1;
                status    = STAT_GCALL;
            end
            default: begin
                status = STAT_NONE;
            end
        endcase
    end

    logic [BYTE_W-1:0] unused_width_ref;
    assign unused_width_ref = addr_byte;

endmodule

// File: rtl/sam_checker.sv
module sam_checker #(
    parameter int                ADDR_W    = 7,
    parameter int                STAT_W    = 8,
    parameter logic [STAT_W-1:0] STAT_NONE = 8'hF8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              addr_vld,
    input logic [ADDR_W:0]   addr_byte,
    input logic [ADDR_W:0]   own_reg,
    input logic              ack_en,
    input logic              sel_own,
    input logic              sel_gcall,
    input logic              dir_read,
    input logic              ack_drive,
    input logic [STAT_W-1:0] status
);

    // R9
    hold_no_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(addr_vld) |-> $stable({sel_own, sel_gcall, dir_read, ack_drive, status}));

    // R2
    ack_tracks_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ack_drive == (sel_own || sel_gcall));

    // R2
    sel_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({sel_own, sel_gcall}));

    // R3
    read_needs_own_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dir_read |-> sel_own);

    // R5
    gc_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_vld && !own_reg[0]) |=> !sel_gcall);

    // R6
    gc_read_rejected_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_vld && addr_byte[0]) |=> !sel_gcall);

    // R7
    zero_own_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_vld && own_reg[ADDR_W:1] == '0) |=> !sel_own);

    // R8
    no_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_vld && !ack_en) |=> (!ack_drive && status == STAT_NONE));

endmodule

bind slv_addr_match sam_checker #(
    .ADDR_W   (ADDR_W),
    .STAT_W   (STAT_W),
    .STAT_NONE(STAT_NONE)
) u_sam_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .addr_vld (addr_vld),
    .addr_byte(addr_byte),
    .own_reg  (own_reg),
    .ack_en   (ack_en),
    .sel_own  (sel_own),
    .sel_gcall(sel_gcall),
    .dir_read (dir_read),
    .ack_drive(ack_drive),
    .status   (status)
);

// File: tb/test_slv_addr_match.sv
module test_slv_addr_match;

    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W     = 7;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             addr_vld = 1'b0;
    logic [ADDR_W:0]  addr_byte = '0;
    logic [ADDR_W:0]  own_reg = '0;
    logic             ack_en = 1'b0;

    logic       a_own, a_gc, a_dir, a_ack;
    logic [7:0] a_st;
    logic       b_own, b_gc, b_dir, b_ack;
    logic [7:0] b_st;

    int    n_checks = 0;
    int    n_fail   = 0;
    bit    done     = 1'b0;
    string cur_req  = "R1";

    // model state: 0 none, 1 own write, 2 own read, 3 general call
    int exp_a = 0;
    int exp_b = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    slv_addr_match #(.ADDR_W(ADDR_W), .GC_SUPPORT(1'b1)) i_slv_addr_match (
        .clk(clk), .rst_n(rst_n), .addr_vld(addr_vld), .addr_byte(addr_byte),
        .own_reg(own_reg), .ack_en(ack_en),
        .sel_own(a_own), .sel_gcall(a_gc), .dir_read(a_dir), .ack_drive(a_ack), .status(a_st)
    );

    slv_addr_match #(.ADDR_W(ADDR_W), .GC_SUPPORT(1'b0)) i_slv_addr_match_nogc (
        .clk(clk), .rst_n(rst_n), .addr_vld(addr_vld), .addr_byte(addr_byte),
        .own_reg(own_reg), .ack_en(ack_en),
        .sel_own(b_own), .sel_gcall(b_gc), .dir_read(b_dir), .ack_drive(b_ack), .status(b_st)
    );

    function automatic int model_kind(int b, int o, bit a, bit gcs);
        int addr = b / 2;
        int own  = o / 2;
        bit rd   = (b % 2) == 1;
        if (!a) return 0;
        if (addr == 0) return (gcs && !rd && (o % 2) == 1) ? 3 : 0;
        if (addr == own) return rd ? 2 : 1;
        return 0;
    endfunction

    // packed as {own, gc, dir, ack, status}
    function automatic logic [11:0] expect_vec(int k);
        case (k)
            1:       return {4'b1001, 8'h60};
            2:       return {4'b1011, 8'hA8};
            3:       return {4'b0101, 8'h70};
            default: return {4'b0000, 8'hF8};
        endcase
    endfunction

    task automatic compare(string req, logic [11:0] act, logic [11:0] exp_v);
        n_checks++;
        if (act !== exp_v) begin
            n_fail++;
            $display("FAIL %s: got own/gc/dir/ack=%b status=%h, expected own/gc/dir/ack=%b status=%h",
                     req, act[11:8], act[7:0], exp_v[11:8], exp_v[7:0]);
        end
    endtask

    // reference model update and comparison on every clock
    always @(posedge clk) begin
        if (!rst_n) begin
            exp_a = 0;
            exp_b = 0;
        end else if (addr_vld) begin
            exp_a = model_kind(int'(addr_byte), int'(own_reg), ack_en, 1'b1);
            exp_b = model_kind(int'(addr_byte), int'(own_reg), ack_en, 1'b0);
        end
        #(CLK_PERIOD/4);
        compare(cur_req, {a_own, a_gc, a_dir, a_ack, a_st}, expect_vec(exp_a));
        compare("R11", {b_own, b_gc, b_dir, b_ack, b_st}, expect_vec(exp_b));
    end

    // one strobed byte, then one quiet cycle with scrambled inputs (R9)
    task automatic send(logic [7:0] b, logic [7:0] o, logic a, string req);
        @(negedge clk);
        addr_byte = b;
        own_reg   = o;
        ack_en    = a;
        addr_vld  = 1'b1;
        cur_req   = req;
        @(negedge clk);
        addr_vld  = 1'b0;
        addr_byte = ~b;
        own_reg   = ~o;
        ack_en    = ~a;
        cur_req   = "R9";
        @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: got no completion, expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        cur_req = "R1";
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        send(8'hA0, 8'hA1, 1'b1, "R2");   // own address, write
        send(8'hA1, 8'hA1, 1'b1, "R3");   // own address, read
        send(8'h00, 8'hA1, 1'b1, "R4");   // broadcast, enabled
        send(8'hA2, 8'hA1, 1'b1, "R10");  // miss after a match
        send(8'h00, 8'hA0, 1'b1, "R5");   // broadcast, enable bit clear
        send(8'h01, 8'hA1, 1'b1, "R6");   // broadcast with read
        send(8'h00, 8'h01, 1'b1, "R7");   // zero own field, broadcast still works
        send(8'h00, 8'h00, 1'b1, "R7");   // zero own field, no broadcast
        send(8'h01, 8'h01, 1'b1, "R7");   // zero own field, read
        send(8'hA0, 8'hA1, 1'b0, "R8");   // acknowledge disabled
        send(8'h00, 8'hA1, 1'b0, "R8");
        send(8'hFE, 8'hFF, 1'b1, "R2");   // all-ones address, write
        send(8'hFF, 8'hFF, 1'b1, "R3");   // all-ones address, read

        // sweep of every byte value against a fixed own address
        for (int v = 0; v < 256; v++) begin
            send(8'(v), 8'h5B, 1'b1, "R10");
        end

        // reset after a match returns to the idle state
        send(8'hA1, 8'hA1, 1'b1, "R3");
        @(negedge clk);
        cur_req = "R1";
        rst_n   = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

endmodule